// File: doc/BRIEF.md
# Dual-Modulus Alternating Clock Divider

This block turns a fast reference clock into a slow output clock whose average period is a fractional multiple of the reference period. It runs a fixed number of output periods at one integer divisor, then a fixed number at a second divisor, and repeats. For example, a 24 MHz crystal can be brought to an average of 32.768 kHz this way. With the alternating mode off, only the first divisor is used. A bypass path hands the reference clock straight to the output.

Two gates surround the divider. The input gate freezes the counting state, which is the same as withholding the reference from the dividers. The output gate is sampled only while the divided clock is low, so it never cuts a high pulse short, and the final output comes from a single flop. The intended bring-up order is as follows:
- Keep both gates closed while the divisor and hold fields change.
- Open the input gate.
- Wait for the divider to settle, then open the output gate.

All divisor and hold fields are latched at output period boundaries. Every control input is sampled on the reference clock.

Top module: `dual_mod_clkdiv`

## Requirements
- R1: A divisor field value f gives an output period of exactly f+1 reference cycles, measured from rising edge to rising edge of `clk_o`.
- R2: Each output period is high for floor((f+1)/2) reference cycles and low for the rest. A field value of 0 (divide by one) keeps the output permanently low.
- R3: With `dual_en_i` low, every period uses `div1_i`. The values on `div2_i`, `hold1_i` and `hold2_i` have no effect on the output.
- R4: With `dual_en_i` high, the first period after reset uses `div1_i`. The divider then runs `hold1_i`+1 periods at `div1_i` and `hold2_i`+1 periods at `div2_i`, and repeats this pattern without end.
- R5: With fields div1=732, div2=731, hold1=7 and hold2=10, any 19 consecutive periods span exactly 13916 reference cycles. At 24 MHz this is an average of 32768 Hz.
- R6: A change to a divisor or hold field during a period leaves that period's length unchanged. The new value applies from the next period boundary.
- R7: While `in_gate_i` is low, the divider state does not advance and `clk_o` holds a constant level. Raising the gate again resumes the divider with full-length periods.
- R8: The output gate takes effect only while the divided clock is low. A high pulse already in progress when the gate closes finishes at its full width, after which `clk_o` stays low. Reopening the gate gives complete pulses again.
- R9: With `bypass_i` high, `clk_o` equals `clk_i`.
- R10: Reset (`rst_i`, synchronous, active high) clears both counters, selects the first divisor phase, closes the internal output enable and drives `clk_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_i | input | 1 | Synchronous active-high reset |
| div1_i | input | 12 | First divisor, encoded as divisor minus one |
| div2_i | input | 12 | Second divisor, encoded as divisor minus one |
| hold1_i | input | 12 | Periods spent at the first divisor, minus one |
| hold2_i | input | 12 | Periods spent at the second divisor, minus one |
| dual_en_i | input | 1 | Enables alternation between the two divisors |
| bypass_i | input | 1 | Passes the reference clock to the output undivided |
| in_gate_i | input | 1 | High lets the divider advance |
| out_gate_i | input | 1 | High lets divided pulses reach the output |
| clk_o | output | 1 | Divided (or bypassed) clock |

## Verification
The assertions assume that every control input is synchronous to `clk_i` and that `bypass_i` is held steady around any change, because the bypass mux is combinational on the reference clock. They also assume that a field can change at any cycle, which is why the boundary property checks only when the latched divisor moves. The bench drives all inputs only at falling edges of the reference clock. It changes fields either during reset or in the middle of a period, and it samples `clk_o` at falling edges, except for the bypass test, which samples inside each clock phase.

// File: rtl/dmcd_pkg.sv
`timescale 1ns/1ps
package dmcd_pkg;
  // which divisor the sequencer is currently applying
  typedef enum logic {
    SEG_A = 1'b0,
    SEG_B = 1'b1
  } seg_e;
endpackage

// File: rtl/dmcd_period_ctr.sv
`timescale 1ns/1ps
module dmcd_period_ctr #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         run_i,
  input  logic [W-1:0] n_act_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o,
  output logic         div_o
);
  localparam logic [W:0] ONE_X = {{W{1'b0}}, 1'b1};

  logic [W:0] half_w;

  // high phase length is floor(divisor/2), divisor = field + 1
  assign half_w = ({1'b0, n_act_i} + ONE_X) >> 1;
  assign wrap_o = run_i && (cnt_o == n_act_i);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_o <= '0;
      div_o <= 1'b0;
    end else if (run_i) begin
      div_o <= ({1'b0, cnt_o} < half_w);
      cnt_o <= wrap_o ? '0 : cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/dmcd_seq.sv
`timescale 1ns/1ps
module dmcd_seq
  import dmcd_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         wrap_i,
  input  logic         dual_i,
  input  logic [W-1:0] div1_i,
  input  logic [W-1:0] div2_i,
  input  logic [W-1:0] hold1_i,
  input  logic [W-1:0] hold2_i,
  output logic [W-1:0] n_act_o,
  output seg_e         seg_o,
  output logic [W-1:0] hold_o
);
  logic [W-1:0] lim_w;

  assign lim_w = (seg_o == SEG_A) ? hold1_i : hold2_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      seg_o   <= SEG_A;
      hold_o  <= '0;
      n_act_o <= div1_i;
    end else if (wrap_i) begin
      if (!dual_i) begin
        seg_o   <= SEG_A;
        hold_o  <= '0;
        n_act_o <= div1_i;
      end else if (hold_o >= lim_w) begin
        // phase finished: swap divisor
        seg_o   <= (seg_o == SEG_A) ? SEG_B : SEG_A;
        hold_o  <= '0;
        n_act_o <= (seg_o == SEG_A) ? div2_i : div1_i;
      end else begin
        hold_o  <= hold_o + 1'b1;
        n_act_o <= (seg_o == SEG_A) ? div1_i : div2_i;
      end
    end
  end
endmodule

// File: rtl/dmcd_out_gate.sv
`timescale 1ns/1ps
module dmcd_out_gate (
  input  logic clk_i,
  input  logic rst_i,
  input  logic div_i,
  input  logic gate_i,
  output logic out_o
);
  logic en_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      en_q  <= 1'b0;
      out_o <= 1'b0;
    end else begin
      // enable only moves while the divided clock is low
      if (!div_i) en_q <= gate_i;
      out_o <= div_i & en_q;
    end
  end
endmodule

// File: rtl/dual_mod_clkdiv.sv
`timescale 1ns/1ps
module dual_mod_clkdiv
  import dmcd_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] div1_i,
  input  logic [W-1:0] div2_i,
  input  logic [W-1:0] hold1_i,
  input  logic [W-1:0] hold2_i,
  input  logic         dual_en_i,
  input  logic         bypass_i,
  input  logic         in_gate_i,
  input  logic         out_gate_i,
  output logic         clk_o
);
  logic [W-1:0] cnt_w;
  logic [W-1:0] n_act_w;
  logic [W-1:0] hold_w;
  logic         wrap_w;
  logic         div_w;
  logic         out_w;
  seg_e         seg_w;

  dmcd_period_ctr #(.W(W)) ctr_i (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .run_i  (in_gate_i),
    .n_act_i(n_act_w),
    .cnt_o  (cnt_w),
    .wrap_o (wrap_w),
    .div_o  (div_w)
  );

  dmcd_seq #(.W(W)) seq_i (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .wrap_i (wrap_w),
    .dual_i (dual_en_i),
    .div1_i (div1_i),
    .div2_i (div2_i),
    .hold1_i(hold1_i),
    .hold2_i(hold2_i),
    .n_act_o(n_act_w),
    .seg_o  (seg_w),
    .hold_o (hold_w)
  );

  dmcd_out_gate gate_i (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .div_i (div_w),
    .gate_i(out_gate_i),
    .out_o (out_w)
  );

  assign clk_o = bypass_i ? clk_i : out_w;
endmodule

// File: rtl/dmcd_checker.sv
`timescale 1ns/1ps
module dmcd_checker #(
  parameter int W = 12
) (
  input logic         clk_i,
  input logic         rst_i,
  input logic         in_gate_i,
  input logic         dual_en_i,
  input logic [W-1:0] cnt,
  input logic [W-1:0] n_act,
  input logic [W-1:0] hold,
  input logic         seg,
  input logic         div_q,
  input logic         out_q
);
  // R10: reset clears counters, phase and output
  assert_reset_state_R10: assert property (@(posedge clk_i)
    rst_i |=> (cnt == '0 && hold == '0 && !seg && !div_q && !out_q));

  // R1: the period counter never runs past the latched divisor
  assert_cnt_range_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt <= n_act);

  // R6: the latched divisor moves only on the last cycle of a period
  assert_boundary_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$stable(n_act) && !$past(rst_i)) |-> ($past(cnt) == $past(n_act)));

  // R7: closed input gate freezes the divider
  assert_freeze_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    !in_gate_i |=> ($stable(cnt) && $stable(div_q) && $stable(hold)));

  // R8: output only falls after the divided clock has fallen
  assert_no_trunc_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(out_q) |-> !$past(div_q));

  // R3: without alternation the sequencer stays in the first phase
  assert_single_seg_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (!dual_en_i && $past(!dual_en_i) && !$past(rst_i) && (cnt == '0) && !$stable(cnt)) |-> !seg);
endmodule

bind dual_mod_clkdiv dmcd_checker #(.W(W)) chk_i (
  .clk_i    (clk_i),
  .rst_i    (rst_i),
  .in_gate_i(in_gate_i),
  .dual_en_i(dual_en_i),
  .cnt      (cnt_w),
  .n_act    (n_act_w),
  .hold     (hold_w),
  .seg      (seg_w),
  .div_q    (div_w),
  .out_q    (out_w)
);

// File: tb/dual_mod_clkdiv_tb_top.sv
`timescale 1ns/1ps
module dual_mod_clkdiv_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] n1 = 12'd1, n2 = 12'd1, m1 = 12'd0, m2 = 12'd0;
  logic        dual = 1'b0, byp = 1'b0, ig = 1'b1, og = 1'b1;
  wire         clk_o;
  int          nvec = 0;
  int          nerr = 0;

  always #5 clk = ~clk;

  dual_mod_clkdiv dut_i (
    .clk_i(clk), .rst_i(rst), .div1_i(n1), .div2_i(n2),
    .hold1_i(m1), .hold2_i(m2), .dual_en_i(dual), .bypass_i(byp),
    .in_gate_i(ig), .out_gate_i(og), .clk_o(clk_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(clk_o == 1'b0, "R10", int'(clk_o), 0);
    rst = 1'b0;
  endtask

  task automatic wait_rise();
    bit p;
    bit seen;
    p = clk_o;
    seen = 1'b0;
    while (!seen) begin
      @(negedge clk);
      if (clk_o && !p) seen = 1'b1;
      p = clk_o;
    end
  endtask

  // call positioned on a rising sample; ends on the next rising sample
  task automatic measure(output int hi, output int per);
    int lo;
    hi = 1;
    @(negedge clk);
    while (clk_o) begin hi++; @(negedge clk); end
    lo = 1;
    @(negedge clk);
    while (!clk_o) begin lo++; @(negedge clk); end
    per = hi + lo;
  endtask

  function automatic int exp_field(input int k, input bit d, input int f1,
                                   input int f2, input int h1, input int h2);
    int pos;
    if (!d) return f1;
    pos = k % (h1 + h2 + 2);
    return (pos < h1 + 1) ? f1 : f2;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL R10 watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    int hi, per, ef, sum;
    bit v, okc;
    @(negedge clk);

    // R1 R3: single mode sweep with distracting second-phase fields
    for (int f = 1; f <= 6; f++) begin
      n1 = 12'(f); n2 = 12'(9 - f); m1 = 12'(f % 3); m2 = 12'd2; dual = 1'b0;
      do_reset();
      wait_rise();
      for (int k = 0; k < 4; k++) begin
        measure(hi, per);
        chk(per == f + 1, "R1", per, f + 1);
        chk(hi == (f + 1) / 2, "R3", hi, (f + 1) / 2);
      end
    end

    // R4 R2: dual mode sweep
    for (int a = 1; a <= 4; a++)
      for (int b = 1; b <= 4; b++)
        for (int c = 0; c <= 2; c++)
          for (int d = 0; d <= 2; d++) begin
            n1 = 12'(a); n2 = 12'(b); m1 = 12'(c); m2 = 12'(d); dual = 1'b1;
            do_reset();
            wait_rise();
            for (int k = 0; k < 2 * (c + d + 2); k++) begin
              measure(hi, per);
              ef = exp_field(k, 1'b1, a, b, c, d);
              chk(per == ef + 1, "R4", per, ef + 1);
              chk(hi == (ef + 1) / 2, "R2", hi, (ef + 1) / 2);
            end
          end

    // R2: divide by one stays low
    n1 = 12'd0; dual = 1'b0;
    do_reset();
    okc = 1'b1;
    repeat (30) begin @(negedge clk); if (clk_o) okc = 1'b0; end
    chk(okc, "R2", int'(!okc), 0);

    // R6: mid-period change applies at the next boundary
    n1 = 12'd7; dual = 1'b0;
    do_reset();
    wait_rise();
    n1 = 12'd3;
    measure(hi, per);
    chk(per == 8, "R6", per, 8);
    measure(hi, per);
    chk(per == 4, "R6", per, 4);

    // R7: input gate freeze and resume
    n1 = 12'd7;
    do_reset();
    wait_rise();
    measure(hi, per);
    ig = 1'b0;
    repeat (2) @(negedge clk);
    v = clk_o;
    okc = 1'b1;
    repeat (20) begin @(negedge clk); if (clk_o != v) okc = 1'b0; end
    chk(okc, "R7", int'(!okc), 0);
    ig = 1'b1;
    wait_rise();
    measure(hi, per);
    chk(per == 8, "R7", per, 8);

    // R8: output gate closed during a high pulse
    do_reset();
    wait_rise();
    og = 1'b0;
    hi = 1;
    @(negedge clk);
    while (clk_o) begin hi++; @(negedge clk); end
    chk(hi == 4, "R8", hi, 4);
    okc = 1'b1;
    repeat (30) begin @(negedge clk); if (clk_o) okc = 1'b0; end
    chk(okc, "R8", int'(!okc), 0);
    og = 1'b1;
    wait_rise();
    measure(hi, per);
    chk(hi == 4, "R8", hi, 4);
    chk(per == 8, "R8", per, 8);

    // R9: bypass follows the reference clock
    byp = 1'b1;
    repeat (8) begin
      @(posedge clk); #2.5;
      chk(clk_o == 1'b1, "R9", int'(clk_o), 1);
      @(negedge clk); #2.5;
      chk(clk_o == 1'b0, "R9", int'(clk_o), 0);
    end
    @(negedge clk);
    byp = 1'b0;

    // R5: fractional reference setting
    n1 = 12'd732; n2 = 12'd731; m1 = 12'd7; m2 = 12'd10; dual = 1'b1;
    do_reset();
    wait_rise();
    for (int r = 0; r < 2; r++) begin
      sum = 0;
      for (int k = 0; k < 19; k++) begin
        measure(hi, per);
        sum += per;
      end
      chk(sum == 13916, "R5", sum, 13916);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule